// File: doc/BRIEF.md
# Selectable-Length Pulse Burst Generator

This block emits a one-shot train of single-cycle pulses whose length is chosen from one, two, four or eight pulses. A programmable down-counting rate divider, clocked by the system clock, sets the pulse spacing in clock cycles. A run latch decides whether the divider's ticks reach the output. While the latch is set, a binary chain of toggle stages counts the pulses that pass. The run latch is set by a rising edge on the start input.

When the counter stage picked by the length selector switches from 0 to 1, the latch drops straight away and the output goes quiet. A done flag then holds the block locked out. Further start edges do nothing until reset clears the counter, the latch and the flag together. Reset and start are both brought into the clock domain through two flip-flops. Reset asserts asynchronously and is released on a clock edge.

Top module: `pulse_burst_gen`

## Requirements
- R1: While reset is asserted, and after it is released, pulse, busy and done are all 0 until a start is accepted.
- R2: A start input that rises while busy and done are both 0 is accepted, and busy rises on the third rising clock edge counted from the start change.
- R3: With divisor N (a divisor of 0 behaves as 1), pulse is high for one cycle at a time. The first pulse falls in the N-th cycle that busy is high, and each later pulse follows N cycles after the one before, so busy stays high for exactly (burst length × N) cycles.
- R4: The burst length selector is captured when start is accepted. Code 0 gives 1 pulse, 1 gives 2, 2 gives 4 and 3 gives 8. A change to the selector during a burst does not alter the count.
- R5: On the clock edge that ends the cycle carrying the last pulse, busy falls and done rises.
- R6: pulse is never high while busy is low.
- R7: A start rising edge during a burst is ignored: the burst keeps its original pulse count and does not restart.
- R8: Once done is set, it stays set and busy and pulse stay low, whatever the start input does, until reset.
- R9: Asserting reset clears pulse, busy and done at once, even mid-burst. Reset asserted in the cycle of the final pulse wins over termination, so done does not get set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Burst request, acted on at its rising edge |
| len_sel_i | input | LEN_W | Burst length code: the burst has 2^code pulses |
| divisor_i | input | DIV_W | Pulse period in clock cycles (0 treated as 1) |
| pulse_o | output | 1 | Single-cycle output pulse |
| busy_o | output | 1 | Run latch state: a burst is in progress |
| done_o | output | 1 | Burst finished; the block is locked out until reset |

## Verification
The bench builds the block with its default widths: a 16-bit divisor and a 2-bit length code, which gives counter taps for all four burst lengths. The bench drives small divisors (0, 1, 2, 3, 5, 6) so that every length, including the eight-pulse tap, finishes within a few dozen cycles. This also covers back-to-back pulses, where divisor 0 or 1 leaves no gap between pulses. The same short periods make it cheap to place a start edge or a reset exactly on the cycle of the final pulse.

// File: rtl/pulse_burst_pkg.sv
package pulse_burst_pkg;

  // Default widths for the rate divisor and the length code.
  localparam int unsigned DEF_DIV_W   = 16;
  localparam int unsigned DEF_LEN_W   = 2;
  localparam int unsigned DEF_SYNC_FF = 2;

  // Run latch and terminal flag carried together.
  typedef struct packed {
    logic run;
    logic done;
  } burst_flags_t;

endpackage

// File: rtl/pb_reset_sync.sv
module pb_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/pb_start_edge.sv
module pb_start_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;
  logic              prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], start_i};
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/pb_rate_div.sv
module pb_rate_div #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] divisor_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;
  logic [DIV_W-1:0] reload;
  logic             at_zero;
  logic             cnt_en;

  always_comb begin
    reload  = (divisor_i == '0) ? '0 : (divisor_i - DIV_W'(1));
    at_zero = (cnt_q == '0);
    cnt_en  = load_i | run_i;
    if (load_i)       cnt_d = reload;
    else if (at_zero) cnt_d = reload;
    else              cnt_d = cnt_q - DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // Raw terminal-count tick; gating by the run latch happens downstream.
  assign tick_o = at_zero;
endmodule

// File: rtl/pb_tap_counter.sv
module pb_tap_counter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  output logic [CNT_W-1:0] rise_o
);
  logic [CNT_W-1:0] q_q;
  logic [CNT_W-1:0] q_d;
  logic [CNT_W:0]   carry;

  assign carry[0] = adv_i;

  // Ripple chain of toggle stages: stage k flips when all lower stages are 1.
  for (genvar k = 0; k < CNT_W; k++) begin : g_stage
    assign carry[k+1] = carry[k] & q_q[k];
    assign q_d[k]     = q_q[k] ^ carry[k];
    assign rise_o[k]  = carry[k] & ~q_q[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_q <= '0;
    else if (adv_i) q_q <= q_d;
  end
endmodule

// File: rtl/pb_burst_ctrl.sv
module pb_burst_ctrl
  import pulse_burst_pkg::*;
#(
  parameter int unsigned LEN_W = 2,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_rise_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] tap_rise_i,
  output logic             load_o,
  output logic             pulse_o,
  output logic             run_o,
  output logic             done_o,
  output logic [LEN_W-1:0] len_q_o
);
  burst_flags_t     flg_q;
  burst_flags_t     flg_d;
  logic [LEN_W-1:0] len_q;
  logic             accept;
  logic             term;

  always_comb begin
    accept  = start_rise_i & ~flg_q.run & ~flg_q.done;
    pulse_o = tick_i & flg_q.run;
    term    = pulse_o & tap_rise_i[len_q];
    flg_d   = flg_q;
    if (accept)    flg_d.run = 1'b1;
    else if (term) flg_d.run = 1'b0;
    flg_d.done = flg_q.done | term;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg_q <= '0;
    else        flg_q <= flg_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= '0;
    else if (accept) len_q <= len_i;
  end

  assign load_o  = accept;
  assign run_o   = flg_q.run;
  assign done_o  = flg_q.done;
  assign len_q_o = len_q;
endmodule

// File: rtl/pulse_burst_gen.sv
module pulse_burst_gen
  import pulse_burst_pkg::*;
#(
  parameter int unsigned DIV_W   = DEF_DIV_W,
  parameter int unsigned LEN_W   = DEF_LEN_W,
  parameter int unsigned SYNC_FF = DEF_SYNC_FF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_sel_i,
  input  logic [DIV_W-1:0] divisor_i,
  output logic             pulse_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int unsigned CNT_W = 1 << LEN_W;

  logic             rst_int_n;
  logic             start_rise;
  logic             load;
  logic             tick;
  logic             run;
  logic [CNT_W-1:0] tap_rise;
  logic [LEN_W-1:0] len_q;

  pb_reset_sync #(.STAGES(SYNC_FF)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_int_n)
  );

  pb_start_edge #(.STAGES(SYNC_FF)) u_start (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start_i (start_i),
    .rise_o  (start_rise)
  );

  pb_rate_div #(.DIV_W(DIV_W)) u_rate (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load_i    (load),
    .run_i     (run),
    .divisor_i (divisor_i),
    .tick_o    (tick)
  );

  pb_tap_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .adv_i  (pulse_o),
    .rise_o (tap_rise)
  );

  pb_burst_ctrl #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .start_rise_i (start_rise),
    .len_i        (len_sel_i),
    .tick_i       (tick),
    .tap_rise_i   (tap_rise),
    .load_o       (load),
    .pulse_o      (pulse_o),
    .run_o        (run),
    .done_o       (done_o),
    .len_q_o      (len_q)
  );

  assign busy_o = run;
endmodule

// File: rtl/pulse_burst_chk.sv
module pulse_burst_chk #(
  parameter int unsigned LEN_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pulse,
  input logic             busy,
  input logic             done,
  input logic [LEN_W-1:0] len_q
);
  localparam int unsigned PW = (1 << LEN_W) + 1;

  logic [PW-1:0] burst_cnt;

  // Pulses of the current or just-finished burst; held once done is set.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             burst_cnt <= '0;
    else if (pulse)         burst_cnt <= burst_cnt + PW'(1);
    else if (!busy && !done) burst_cnt <= '0;
  end

  a_r6_pulse_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> busy);

  a_r8_done_excludes_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  a_r5_end_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r4_burst_length: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && done) |-> (int'(burst_cnt) == (1 << len_q)));
endmodule

bind pulse_burst_gen pulse_burst_chk #(.LEN_W(LEN_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .pulse (pulse_o),
  .busy  (busy_o),
  .done  (done_o),
  .len_q (len_q)
);

// File: tb/pulse_burst_gen_test.sv
module pulse_burst_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 16;
  localparam int LEN_W = 2;
  localparam int WATCHDOG = 100000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [LEN_W-1:0] len_sel_i = '0;
  logic [DIV_W-1:0] divisor_i = 16'd1;
  logic             pulse_o, busy_o, done_o;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  int obs = 0;

  pulse_burst_gen #(.DIV_W(DIV_W), .LEN_W(LEN_W)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_sel_i(len_sel_i),
    .divisor_i(divisor_i), .pulse_o(pulse_o), .busy_o(busy_o), .done_o(done_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model, updated on every rising edge.
  bit m_r1, m_r2, m_old, m_s1, m_s2, m_prev, m_run, m_done, m_acc;
  int m_wait, m_emit, m_target, m_eff;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_r1 = 0; m_r2 = 0; m_s1 = 0; m_s2 = 0; m_prev = 0;
      m_run = 0; m_done = 0; m_wait = 0; m_emit = 0; m_target = 1;
    end else begin
      m_old = m_r2; m_r2 = m_r1; m_r1 = 1;
      if (!m_old) begin
        m_s1 = 0; m_s2 = 0; m_prev = 0; m_run = 0; m_done = 0;
      end else begin
        m_eff = (divisor_i == 0) ? 1 : int'(divisor_i);
        m_acc = m_s2 && !m_prev && !m_run && !m_done;
        m_prev = m_s2; m_s2 = m_s1; m_s1 = start_i;
        if (m_run) begin
          if (m_wait == 1) begin
            m_emit++;
            m_wait = m_eff;
            if (m_emit == m_target) begin m_run = 0; m_done = 1; end
          end else m_wait--;
        end
        if (m_acc) begin
          m_run = 1; m_wait = m_eff; m_emit = 0; m_target = 1 << len_sel_i;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model (R3 R5 R6 R8).
  always @(negedge clk) begin
    check(pulse_o == (m_run && m_wait == 1), "R3/R6", "pulse vs model",
          int'(pulse_o), int'(m_run && m_wait == 1));
    check(busy_o == m_run, "R5", "busy vs model", int'(busy_o), int'(m_run));
    check(done_o == m_done, "R8", "done vs model", int'(done_o), int'(m_done));
    if (pulse_o) obs++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles >= WATCHDOG) begin
      fails++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    start_i = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(4);
  endtask

  task automatic wait_done(input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (done_o) break;
    end
    #1;
  endtask

  task automatic run_burst(input int sel, input int div);
    int base, bcyc, eff;
    eff = (div == 0) ? 1 : div;
    len_sel_i = LEN_W'(sel);
    divisor_i = DIV_W'(div);
    base = obs;
    bcyc = 0;
    start_i = 1'b1;
    @(negedge clk); check(busy_o == 0, "R2", "busy after 1 edge", int'(busy_o), 0);
    @(negedge clk); check(busy_o == 0, "R2", "busy after 2 edges", int'(busy_o), 0);
    @(negedge clk); check(busy_o == 1, "R2", "busy after 3 edges", int'(busy_o), 1);
    for (int i = 0; i < 2000; i++) begin
      if (busy_o) bcyc++;
      if (done_o) break;
      @(negedge clk);
    end
    #1;
    check(obs - base == (1 << sel), "R4", "pulses in burst", obs - base, 1 << sel);
    check(bcyc == (1 << sel) * eff, "R3", "busy-high cycles", bcyc, (1 << sel) * eff);
    check(done_o == 1 && busy_o == 0, "R5", "done set busy clear",
          int'({done_o, busy_o}), 2);
  endtask

  initial begin
    int base;
    step(2);
    check(pulse_o == 0 && busy_o == 0 && done_o == 0, "R1", "outputs in reset",
          int'({pulse_o, busy_o, done_o}), 0);
    rst_n = 1'b1;
    step(5);
    check(pulse_o == 0 && busy_o == 0 && done_o == 0, "R1", "outputs after reset",
          int'({pulse_o, busy_o, done_o}), 0);

    run_burst(0, 3);
    do_reset();
    run_burst(1, 1);
    do_reset();
    run_burst(2, 5);
    do_reset();

    // R8: start edges after completion are ignored
    run_burst(3, 2);
    base = obs;
    start_i = 1'b0; step(4);
    start_i = 1'b1; step(30);
    check(obs == base, "R8", "pulses after done", obs - base, 0);
    check(done_o == 1 && busy_o == 0, "R8", "still locked out",
          int'({done_o, busy_o}), 2);
    do_reset();

    // divisor 0 behaves as 1: back-to-back pulses
    run_burst(3, 0);
    do_reset();

    // R7: start re-edge during burst is ignored
    len_sel_i = 2'd2; divisor_i = 16'd5; base = obs;
    start_i = 1'b1; step(6);
    start_i = 1'b0; step(3);
    start_i = 1'b1;
    wait_done(500);
    check(obs - base == 4, "R7", "count with start re-edge", obs - base, 4);
    do_reset();

    // R4: selector captured at accept
    len_sel_i = 2'd2; divisor_i = 16'd2; base = obs;
    start_i = 1'b1; step(4);
    len_sel_i = 2'd0;
    wait_done(500);
    check(obs - base == 4, "R4", "selector changed mid-burst", obs - base, 4);
    do_reset();

    // R9: reset mid-burst clears at once
    len_sel_i = 2'd3; divisor_i = 16'd4;
    start_i = 1'b1; step(12);
    rst_n = 1'b0; #1;
    check(pulse_o == 0 && busy_o == 0 && done_o == 0, "R9", "async clear mid-burst",
          int'({pulse_o, busy_o, done_o}), 0);
    start_i = 1'b0; step(2);
    rst_n = 1'b1; step(4);

    // R9: reset in the cycle of the final pulse beats termination
    len_sel_i = 2'd0; divisor_i = 16'd6;
    start_i = 1'b1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (pulse_o) break;
    end
    #1;
    check(pulse_o == 1, "R9", "final pulse present", int'(pulse_o), 1);
    rst_n = 1'b0;
    @(negedge clk);
    check(done_o == 0 && busy_o == 0, "R9", "reset wins over termination",
          int'({done_o, busy_o}), 0);
    #1; start_i = 1'b0;
    step(2);
    rst_n = 1'b1; step(4);
    check(done_o == 0 && busy_o == 0 && pulse_o == 0, "R1", "idle after reset",
          int'({pulse_o, busy_o, done_o}), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule